// File: doc/BRIEF.md
# Wiper Position Counter with Tap Decoder

This block keeps the volatile tap position of one digitally controlled potentiometer and turns it into the select lines for the tap switches. The position is six bits wide by default. It can change in four ways: a direct write from the host, a parallel transfer from one of the stored data registers, single-tap steps up or down, and a load of the stored register-0 value during reset. The host write and the transfer both come in on the same load strobe with a value. The surrounding logic picks which source drives that value.

The position decodes to a one-hot switch-select vector, so exactly one tap switch is closed at a time. Position zero closes the switch at the low end of the resistor string, and the all-ones position closes the switch at the high end. A step never wraps past either end. The select vector is registered, so it follows the position one clock later.

Top module: `wiper_tap_ctl`

## Requirements
- R1: While `rst_n` is low, each rising clock edge loads `pos` with `boot_val`. After reset is released, `pos` holds the value `boot_val` had at the last reset edge, not any earlier position.
- R2: Outside reset, `tap_sel` has exactly one bit set.
- R3: The set bit of `tap_sel` is the bit whose index equals the position. Position 0 sets bit 0 (the low-terminal switch), and position 63 sets bit 63 (the high-terminal switch).
- R4: When `step_en` is high with `step_up` = 1, `load_en` is low and `pos` is below 63, `pos` increases by one at the next edge.
- R5: When `step_en` is high with `step_up` = 0, `load_en` is low and `pos` is above 0, `pos` decreases by one at the next edge.
- R6: A step up at position 63 or a step down at position 0 leaves `pos` unchanged, with no wrap-around.
- R7: When `load_en` is high, `pos` takes `load_val` at the next edge. Any 6-bit value can be loaded.
- R8: When `load_en` and `step_en` are high in the same cycle, the load wins and the step is ignored.
- R9: `tap_sel` shows the position one clock after `pos` changes.
- R10: With `load_en` and `step_en` both low, `pos` and `tap_sel` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; each reset edge loads `boot_val` |
| boot_val | input | WIDTH (6) | Stored register-0 value loaded during reset |
| load_en | input | 1 | Load strobe, used for both a host write and a register transfer |
| load_val | input | WIDTH (6) | Value to load |
| step_en | input | 1 | Single-tap step strobe |
| step_up | input | 1 | Step direction: 1 moves toward the high terminal, 0 toward the low terminal |
| pos | output | WIDTH (6) | Current tap position |
| tap_sel | output | 2**WIDTH (64) | Registered one-hot switch select |

## Verification
The hardest cases to reach are the saturation edges with a step still asserted: the position must first be walked or loaded to 0 or 63, and then a step in the outward direction is applied. The bench loads each end value directly. It then applies several outward steps in a row and checks that both the position and the one-hot select stay on the end tap. Load-over-step priority is tested by raising both strobes in one cycle, with the step pointing away from the loaded value. The one-cycle lag of the select is tested by sampling it on the cycle the position changes and again on the cycle after.

// File: rtl/wiper_tap_ctl.sv
module wiper_tap_ctl #(
  parameter int WIDTH = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WIDTH-1:0]        boot_val,
  input  logic                    load_en,
  input  logic [WIDTH-1:0]        load_val,
  input  logic                    step_en,
  input  logic                    step_up,
  output logic [WIDTH-1:0]        pos,
  output logic [(1<<WIDTH)-1:0]   tap_sel
);
  localparam int TAPS = 1 << WIDTH;
  localparam logic [WIDTH-1:0] POS_TOP = '1;
  localparam logic [WIDTH-1:0] POS_BOT = '0;

  logic [WIDTH-1:0] pos_nx;
  logic [TAPS-1:0]  decoded;
  logic             at_top, at_bot;

  assign at_top = (pos == POS_TOP);
  assign at_bot = (pos == POS_BOT);

  always_comb begin
    pos_nx = pos;
    if (load_en)
      pos_nx = load_val;
    else if (step_en && step_up && !at_top)
      pos_nx = pos + 1'b1;
    else if (step_en && !step_up && !at_bot)
      pos_nx = pos - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pos <= boot_val;
    else        pos <= pos_nx;
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_dec
    assign decoded[i] = (pos == WIDTH'(i));
  end

  always_ff @(posedge clk) tap_sel <= decoded;
endmodule

// File: rtl/wiper_tap_chk.sv
module wiper_tap_chk #(
  parameter int WIDTH = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [WIDTH-1:0]      boot_val,
  input logic                  load_en,
  input logic [WIDTH-1:0]      load_val,
  input logic                  step_en,
  input logic                  step_up,
  input logic [WIDTH-1:0]      pos,
  input logic [(1<<WIDTH)-1:0] tap_sel
);
  localparam logic [WIDTH-1:0] POS_TOP = '1;
  localparam logic [WIDTH-1:0] POS_BOT = '0;

  p_reset_load_r1: assert property (@(posedge clk)
    !rst_n |=> pos == $past(boot_val));

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones(tap_sel) == 1);

  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && step_up && !load_en && pos != POS_TOP |=> pos == $past(pos) + 1'b1);

  p_step_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !step_up && !load_en && pos != POS_BOT |=> pos == $past(pos) - 1'b1);

  p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && step_up && !load_en && pos == POS_TOP |=> pos == POS_TOP);

  p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !step_up && !load_en && pos == POS_BOT |=> pos == POS_BOT);

  p_load_r7_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> pos == $past(load_val));

  p_tap_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tap_sel[$past(pos)]);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && !step_en |=> $stable(pos));
endmodule

bind wiper_tap_ctl wiper_tap_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .boot_val(boot_val), .load_en(load_en),
  .load_val(load_val), .step_en(step_en), .step_up(step_up),
  .pos(pos), .tap_sel(tap_sel)
);

// File: tb/tb_wiper_tap_ctl.sv
`timescale 1ns/1ps
module tb_wiper_tap_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  boot_val = 6'd0;
  logic        load_en = 1'b0;
  logic [5:0]  load_val = 6'd0;
  logic        step_en = 1'b0;
  logic        step_up = 1'b0;
  logic [5:0]  pos;
  logic [63:0] tap_sel;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  wiper_tap_ctl #(.WIDTH(6)) dut (
    .clk(clk), .rst_n(rst_n), .boot_val(boot_val), .load_en(load_en),
    .load_val(load_val), .step_en(step_en), .step_up(step_up),
    .pos(pos), .tap_sel(tap_sel)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] oh(input int p);
    return 64'd1 << p;
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_load(input logic [5:0] v);
    load_en = 1'b1; load_val = v; cyc(1); load_en = 1'b0;
  endtask

  task automatic do_step(input logic up);
    step_en = 1'b1; step_up = up; cyc(1); step_en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; boot_val = 6'd17; cyc(2);
    boot_val = 6'd42; cyc(2);
    rst_n = 1'b1; boot_val = 6'd5; cyc(1);
    chk("R1 reset loads register-0 value", 64'(pos), 64'd42);
    chk("R2 R3 select after reset", tap_sel, oh(42));
  endtask

  task automatic t_load;
    do_load(6'd9);
    chk("R7 load value", 64'(pos), 64'd9);
    cyc(1);
    chk("R3 select follows load", tap_sel, oh(9));
    do_load(6'd0); cyc(1);
    chk("R3 position 0 selects low tap", tap_sel, oh(0));
    do_load(6'd63); cyc(1);
    chk("R3 position 63 selects high tap", tap_sel, oh(63));
  endtask

  task automatic t_step_up;
    do_load(6'd30);
    do_step(1'b1);
    chk("R4 step up", 64'(pos), 64'd31);
    do_step(1'b1);
    chk("R4 second step up", 64'(pos), 64'd32);
    cyc(1);
    chk("R4 select after steps", tap_sel, oh(32));
  endtask

  task automatic t_step_down;
    do_load(6'd1);
    do_step(1'b0);
    chk("R5 step down", 64'(pos), 64'd0);
    do_load(6'd50);
    do_step(1'b0); do_step(1'b0); do_step(1'b0);
    chk("R5 three steps down", 64'(pos), 64'd47);
  endtask

  task automatic t_saturate;
    do_load(6'd63);
    for (int i = 0; i < 3; i++) do_step(1'b1);
    chk("R6 saturate at top", 64'(pos), 64'd63);
    chk("R6 R2 top select", tap_sel, oh(63));
    do_load(6'd0);
    for (int i = 0; i < 3; i++) do_step(1'b0);
    chk("R6 saturate at bottom", 64'(pos), 64'd0);
    chk("R6 R2 bottom select", tap_sel, oh(0));
  endtask

  task automatic t_priority;
    do_load(6'd20);
    load_en = 1'b1; load_val = 6'd10; step_en = 1'b1; step_up = 1'b1;
    cyc(1);
    load_en = 1'b0; step_en = 1'b0;
    chk("R8 load beats step up", 64'(pos), 64'd10);
    load_en = 1'b1; load_val = 6'd63; step_en = 1'b1; step_up = 1'b0;
    cyc(1);
    load_en = 1'b0; step_en = 1'b0;
    chk("R8 load beats step down", 64'(pos), 64'd63);
  endtask

  task automatic t_lag;
    do_load(6'd12); cyc(1);
    do_load(6'd13);
    chk("R9 pos changed", 64'(pos), 64'd13);
    chk("R9 select still old", tap_sel, oh(12));
    cyc(1);
    chk("R9 select one cycle later", tap_sel, oh(13));
  endtask

  task automatic t_idle;
    do_load(6'd37); cyc(4);
    chk("R10 pos holds when idle", 64'(pos), 64'd37);
    chk("R10 select holds when idle", tap_sel, oh(37));
  endtask

  initial begin
    t_reset();
    t_load();
    t_step_up();
    t_step_down();
    t_saturate();
    t_priority();
    t_lag();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule